// File: doc/BRIEF.md
# Output Rounding, Saturation and Format Stage

This block sits at the end of a filter datapath and turns two wide signed results into two 16-bit output words. The number of significant bits kept is chosen at run time by a 3-bit select. The result is rounded at that precision, clamped if it no longer fits in 16 bits, and the bits below the chosen precision are cleared. A format bit can then turn the two's complement word into offset binary by flipping its top bit.

Both lanes share the valid strobe, the precision select and the format bit, and each lane has its own active-low output enable. The enables are passed out as registered, active-high drive indications so that the pad ring can build the three-state buffers. Data, valid and drive indications all appear one clock after they are presented. When no valid sample arrives, the output words keep their last value.

Top module: `hb_out_fmt`

## Requirements
- R1: `out_vld` follows `in_vld` one clock later; `out_a`/`out_b` load only on a cycle with `in_vld` high and otherwise keep their value, whatever the data inputs do.
- R2: `rnd_sel` codes 0,1,2,3,4,5,6,7 keep 8,9,10,11,12,14,16,16 significant bits of the 16-bit word, and every bit below the kept precision is zero.
- R3: Rounding adds one half of the kept LSB before truncation, so an exact half rounds toward plus infinity. The input carries `FRAC` bits below the LSB of the 16-bit word.
- R4: If the rounded value is above +32767 the word is the largest positive value at the chosen precision (0x7FFF with its low bits cleared). If it is below -32768 the word is 0x8000.
- R5: With `fmt_ofs` high, bit 15 of each output is inverted after saturation and masking. With it low, the output is two's complement.
- R6: `drv_a` and `drv_b` equal the inverse of `oe_a_n` and `oe_b_n` one clock earlier, on every cycle whether or not a sample is valid.
- R7: A synchronous active-high reset clears `out_a`, `out_b`, `out_vld`, `drv_a` and `drv_b`.
- R8: The two lanes are processed independently with the shared precision and format settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Input sample valid for both lanes |
| in_a | input | IN_W | Lane A wide signed result |
| in_b | input | IN_W | Lane B wide signed result |
| rnd_sel | input | 3 | Precision select code |
| fmt_ofs | input | 1 | 1 = offset binary, 0 = two's complement |
| oe_a_n | input | 1 | Lane A output enable, active low |
| oe_b_n | input | 1 | Lane B output enable, active low |
| out_a | output | OUT_W | Lane A formatted word |
| out_b | output | OUT_W | Lane B formatted word |
| out_vld | output | 1 | Output word valid |
| drv_a | output | 1 | Lane A drive indication, active high |
| drv_b | output | 1 | Lane B drive indication, active high |

## Verification
The saturation properties assume the input has at least one integer guard bit above the 16-bit field. They are checked only for positive overflow, because a negative input just past the range can round back inside it. The hold and latency properties assume that the precision, format and data inputs matter only on valid cycles. The stimulus changes data, precision and format freely on idle cycles to show that they are ignored there. Vectors place values exactly on, just under and just beyond each rounding point and saturation limit for every select code. Randomized data is then sent independently to the two lanes.

// File: rtl/hb_out_pkg.sv
package hb_out_pkg;
  localparam int SEL_W  = 3;
  localparam int PREC_W = 5;

  function automatic logic [PREC_W-1:0] prec_bits(input logic [SEL_W-1:0] code);
    logic [PREC_W-1:0] p;
    case (code)
      3'd0:    p = 5'd8;
      3'd1:    p = 5'd9;
      3'd2:    p = 5'd10;
      3'd3:    p = 5'd11;
      3'd4:    p = 5'd12;
      3'd5:    p = 5'd14;
      default: p = 5'd16;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/hb_rnd_sat.sv
module hb_rnd_sat
  import hb_out_pkg::*;
#(
  parameter int IN_W  = 24,
  parameter int FRAC  = 6,
  parameter int OUT_W = 16
) (
  input  logic [IN_W-1:0]   din,
  input  logic [PREC_W-1:0] prec,
  output logic [OUT_W-1:0]  dsat
);
  localparam int SUM_W = IN_W + 1;
  localparam int TOP_W = SUM_W - FRAC - OUT_W + 1;

  logic [SUM_W-1:0] rnd_c;
  logic [SUM_W-1:0] sum;
  logic [TOP_W-1:0] top;
  logic             ovf;
  int               pos;

  always_comb begin
    pos   = FRAC + OUT_W - int'(prec) - 1;
    rnd_c = '0;
    if (pos >= 0) rnd_c = SUM_W'(1) << pos;
  end

  assign sum = {din[IN_W-1], din} + rnd_c;
  assign top = sum[SUM_W-1 -: TOP_W];
  assign ovf = !((&top) || (~|top));

  always_comb begin
    if (!ovf)
      dsat = sum[FRAC +: OUT_W];
    else if (sum[SUM_W-1])
      dsat = {1'b1, {(OUT_W-1){1'b0}}};
    else
      dsat = {1'b0, {(OUT_W-1){1'b1}}};
  end
endmodule

// File: rtl/hb_lane_out.sv
module hb_lane_out
  import hb_out_pkg::*;
#(
  parameter int OUT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic [PREC_W-1:0] prec,
  input  logic              fmt,
  input  logic [OUT_W-1:0]  dsat,
  input  logic              oe_n,
  output logic [OUT_W-1:0]  q,
  output logic              drv
);
  logic [OUT_W-1:0] keep_m;
  logic [OUT_W-1:0] word;

  assign keep_m = {OUT_W{1'b1}} << (OUT_W - int'(prec));
  assign word   = (dsat & keep_m) ^ {fmt, {(OUT_W-1){1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      q   <= '0;
      drv <= 1'b0;
    end else begin
      drv <= !oe_n;
      if (ld) q <= word;
    end
  end
endmodule

// File: rtl/hb_out_fmt.sv
module hb_out_fmt
  import hb_out_pkg::*;
#(
  parameter int IN_W  = 24,
  parameter int FRAC  = 6,
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic [IN_W-1:0]  in_a,
  input  logic [IN_W-1:0]  in_b,
  input  logic [2:0]       rnd_sel,
  input  logic             fmt_ofs,
  input  logic             oe_a_n,
  input  logic             oe_b_n,
  output logic [OUT_W-1:0] out_a,
  output logic [OUT_W-1:0] out_b,
  output logic             out_vld,
  output logic             drv_a,
  output logic             drv_b
);
  localparam int NLANE = 2;

  logic [PREC_W-1:0] prec;
  logic [IN_W-1:0]   lane_din [NLANE];
  logic              lane_oe  [NLANE];
  logic [OUT_W-1:0]  lane_sat [NLANE];
  logic [OUT_W-1:0]  lane_q   [NLANE];
  logic              lane_drv [NLANE];

  assign prec        = prec_bits(rnd_sel);
  assign lane_din[0] = in_a;
  assign lane_din[1] = in_b;
  assign lane_oe[0]  = oe_a_n;
  assign lane_oe[1]  = oe_b_n;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    hb_rnd_sat #(.IN_W(IN_W), .FRAC(FRAC), .OUT_W(OUT_W)) u_rs (
      .din  (lane_din[g]),
      .prec (prec),
      .dsat (lane_sat[g])
    );
    hb_lane_out #(.OUT_W(OUT_W)) u_out (
      .clk  (clk),
      .rst  (rst),
      .ld   (in_vld),
      .prec (prec),
      .fmt  (fmt_ofs),
      .dsat (lane_sat[g]),
      .oe_n (lane_oe[g]),
      .q    (lane_q[g]),
      .drv  (lane_drv[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) out_vld <= 1'b0;
    else     out_vld <= in_vld;
  end

  assign out_a = lane_q[0];
  assign out_b = lane_q[1];
  assign drv_a = lane_drv[0];
  assign drv_b = lane_drv[1];
endmodule

// File: rtl/hb_out_fmt_chk.sv
module hb_out_fmt_chk
  import hb_out_pkg::*;
#(
  parameter int IN_W  = 24,
  parameter int FRAC  = 6,
  parameter int OUT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             in_vld,
  input logic [IN_W-1:0]  in_a,
  input logic [IN_W-1:0]  in_b,
  input logic [2:0]       rnd_sel,
  input logic             fmt_ofs,
  input logic             oe_a_n,
  input logic             oe_b_n,
  input logic [OUT_W-1:0] out_a,
  input logic [OUT_W-1:0] out_b,
  input logic             out_vld,
  input logic             drv_a,
  input logic             drv_b
);
  logic [OUT_W-1:0] low_q;
  logic             big_a;

  always_ff @(posedge clk) begin
    low_q <= ~({OUT_W{1'b1}} << (OUT_W - int'(prec_bits(rnd_sel))));
  end

  assign big_a = !in_a[IN_W-1] && (|in_a[IN_W-2:FRAC+OUT_W-1]);

  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (rst) in_vld |=> out_vld); // R1
  AST_VLD_DROPS: assert property (@(posedge clk) disable iff (rst) !in_vld |=> !out_vld); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) !in_vld |=> ($stable(out_a) && $stable(out_b))); // R1
  AST_LOW_CLEAR: assert property (@(posedge clk) disable iff (rst) in_vld |=> (((out_a | out_b) & low_q) == '0)); // R2
  AST_SAT_POS: assert property (@(posedge clk) disable iff (rst) (in_vld && !fmt_ofs && big_a) |=> (out_a[OUT_W-1 -: 8] == 8'h7F)); // R4
  AST_SAT_OFS: assert property (@(posedge clk) disable iff (rst) (in_vld && fmt_ofs && big_a) |=> (out_a[OUT_W-1 -: 8] == 8'hFF)); // R5
  AST_DRV_A: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> (drv_a == !$past(oe_a_n))); // R6
  AST_DRV_B: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> (drv_b == !$past(oe_b_n))); // R6
endmodule

bind hb_out_fmt hb_out_fmt_chk #(.IN_W(IN_W), .FRAC(FRAC), .OUT_W(OUT_W)) u_chk (.*);

// File: tb/test_hb_out_fmt.sv
module test_hb_out_fmt;
  localparam int CLK_P = 10;
  localparam int IN_W  = 24;
  localparam int FRAC  = 6;
  localparam int OUT_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_vld = 1'b0;
  logic [IN_W-1:0]  in_a = '0, in_b = '0;
  logic [2:0]       rnd_sel = '0;
  logic             fmt_ofs = 1'b0;
  logic             oe_a_n = 1'b1, oe_b_n = 1'b1;
  logic [OUT_W-1:0] out_a, out_b;
  logic             out_vld, drv_a, drv_b;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  typedef struct {
    logic [OUT_W-1:0] a;
    logic [OUT_W-1:0] b;
    string            tag;
  } exp_t;
  exp_t exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  hb_out_fmt #(.IN_W(IN_W), .FRAC(FRAC), .OUT_W(OUT_W)) i_hb_out_fmt (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_a(in_a), .in_b(in_b),
    .rnd_sel(rnd_sel), .fmt_ofs(fmt_ofs), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
    .out_a(out_a), .out_b(out_b), .out_vld(out_vld), .drv_a(drv_a), .drv_b(drv_b)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  function automatic int kept(input logic [2:0] code);
    int t [8] = '{8, 9, 10, 11, 12, 14, 16, 16};
    return t[code];
  endfunction

  // Reference: round half up at the kept LSB, clamp, clear low bits, flip MSB
  function automatic logic [OUT_W-1:0] model(input logic [IN_W-1:0] x, input logic [2:0] code, input logic f);
    longint v;
    int p;
    int rb;
    logic [OUT_W-1:0] r;
    p  = kept(code);
    v  = longint'($signed(x));
    rb = FRAC + OUT_W - p - 1;
    if (rb >= 0) v = v + (longint'(1) <<< rb);
    v = v >>> FRAC;
    if (v > 32767) v = 32767;
    if (v < -32768) v = -32768;
    r = v[OUT_W-1:0];
    r = r & ~((16'h1 << (OUT_W - p)) - 16'h1);
    if (f) r[OUT_W-1] = ~r[OUT_W-1];
    return r;
  endfunction

  task automatic send(input logic [IN_W-1:0] a, input logic [IN_W-1:0] b, input logic [2:0] code,
                      input logic f, input logic oa, input logic ob, input string tag);
    exp_t e;
    @(negedge clk);
    in_vld = 1'b1; in_a = a; in_b = b; rnd_sel = code; fmt_ofs = f;
    oe_a_n = oa; oe_b_n = ob;
    e.a = model(a, code, f);
    e.b = model(b, code, f);
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_vld = 1'b0;
      in_a = IN_W'($urandom); in_b = IN_W'($urandom);
      rnd_sel = 3'($urandom); fmt_ofs = 1'($urandom);
      oe_a_n = 1'($urandom); oe_b_n = 1'($urandom);
    end
  endtask

  // Monitor: inputs change at negedge, outputs sampled a quarter period after posedge
  logic [OUT_W-1:0] last_a = '0, last_b = '0;
  always @(posedge clk) begin
    #(CLK_P/4);
    if (!rst && !done) begin
      check("R1 out_vld latency", 32'(out_vld), 32'(in_vld));
      check("R6 drv_a", 32'(drv_a), 32'(!oe_a_n));
      check("R6 drv_b", 32'(drv_b), 32'(!oe_b_n));
      if (out_vld) begin
        if (exp_q.size() == 0) begin
          check("R1 unexpected output", 32'(1), 32'(0));
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check({e.tag, " lane A"}, 32'(out_a), 32'(e.a));
          check({e.tag, " lane B"}, 32'(out_b), 32'(e.b));
        end
      end else begin
        check("R1 hold lane A", 32'(out_a), 32'(last_a));
        check("R1 hold lane B", 32'(out_b), 32'(last_b));
      end
      last_a = out_a;
      last_b = out_b;
    end
  end

  initial begin
    #(CLK_P * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    in_a = 24'h123456; in_b = 24'h654321; in_vld = 1'b1; oe_a_n = 1'b0; oe_b_n = 1'b0;
    repeat (3) @(posedge clk);
    #(CLK_P/4);
    // R7: reset clears everything even with live inputs
    check("R7 out_a", 32'(out_a), 32'(0));
    check("R7 out_b", 32'(out_b), 32'(0));
    check("R7 out_vld", 32'(out_vld), 32'(0));
    check("R7 drv_a", 32'(drv_a), 32'(0));
    check("R7 drv_b", 32'(drv_b), 32'(0));
    @(negedge clk);
    rst = 1'b0; in_vld = 1'b0;
    idle(2);

    // R2/R3: rounding points for every code
    for (int c = 0; c < 8; c++) begin
      int rb;
      logic [IN_W-1:0] h;
      rb = FRAC + OUT_W - kept(3'(c)) - 1;
      h  = IN_W'(1) << rb;
      send(h, h - 1, 3'(c), 1'b0, 1'b0, 1'b1, "R3 half up / just below");
      send(-h, -h - 1, 3'(c), 1'b0, 1'b1, 1'b0, "R3 negative half / below");
      send(24'h0ABCDE, 24'hF54321, 3'(c), 1'b0, 1'b0, 1'b0, "R2 precision mask");
      send(24'h1FFFC0, 24'h1FFFFF, 3'(c), 1'b0, 1'b1, 1'b1, "R4 rounding into saturation");
      send(24'h7FFFFF, 24'h800000, 3'(c), 1'b0, 1'b0, 1'b1, "R4 full-scale clamp");
      send(24'h200000, 24'hDFFFFF, 3'(c), 1'b1, 1'b0, 1'b0, "R5 offset binary clamp");
      send(24'h000000, 24'hE00000, 3'(c), 1'b1, 1'b1, 1'b0, "R5 offset binary zero / min");
      idle(1);
    end

    // R8: independent random lanes, mixed idles
    for (int i = 0; i < 300; i++) begin
      send(IN_W'($urandom), IN_W'($urandom), 3'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom), "R8 random lanes");
      if ((i % 7) == 0) idle(1 + (i % 3));
    end
    idle(4);
    check("R1 queue drained", 32'(exp_q.size()), 32'(0));
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule